// File: doc/BRIEF.md
# Display DMA Frame Descriptor Fetcher

This block keeps the descriptor state of the seven DMA channels of a display controller and reloads it once per frame. A pulse on `frame_start_i` starts a two-pass sequence. The load pass visits every enabled channel in ascending order. It picks the descriptor address, which is either the channel's own pointer or a pending one-shot branch target. If that address is inside the permitted memory window, it reads four words over a request/acknowledge memory port. The frame pass then visits the enabled channels again in the same order and reports what each one would do with its frame as tagged event pulses: start of frame, end of frame, or bus error. A separate interrupt block consumes these pulses.

Software uses a flat 32-bit register port to program the descriptor pointers and the branch registers, and to read back the fetched source, identifier and command words. Channel enables are not registers here. They are formed from the controller's main enable, dual-scan, overlay and cursor enable bits, which arrive as inputs.

Top module: `lcd_desc_fetch`

## Requirements
- R1: After reset every channel register reads zero, `busy_o` and `mem_req_o` are low, and no event output is asserted.
- R2: The registers of channel c sit at byte address 0x200+16*c: pointer at +0x0, source at +0x4, identifier at +0x8, command at +0xC. The branch register of channel c sits at 0x100+4*c. Every other address reads zero, and this includes channel indices 7 and above, where writes are also ignored.
- R3: A pointer write stores the data with bits 3:0 forced to zero. A branch write stores the data ANDed with 0xFFFFFFF3. Writes to the source, identifier and command addresses change nothing.
- R4: Channel 0 is enabled by `main_en_i`. Channel 1 is enabled by `ovl1_en_i` OR `dual_scan_i`. Channels 2, 3 and 4 are enabled by `ovl2_en_i`. Channel 5 is enabled by `cursor_en_i`. Channel 6 is never enabled.
- R5: A frame start clears the source register of every channel, enabled or not. A disabled channel issues no reads, raises no event, and keeps its pointer, identifier and command.
- R6: A descriptor at address A is read as four single-word reads at A, A+4, A+8 and A+12, in that order. Each read holds `mem_req_o` and `mem_addr_o` until `mem_ack_i`. The returned words land in pointer, source, identifier and command respectively. Channels are loaded in ascending order.
- R7: When branch bit 0 is set, the channel fetches from branch bits 31:4 (low nibble zero) instead of its pointer, and bit 0 is then cleared while the other branch bits stay. If bit 1 is also set, one branch event tagged with the channel is raised.
- R8: A descriptor is fetched only if A >= WIN_BASE and A+16 <= WIN_BASE+WIN_SIZE. Otherwise no read is issued, the source stays zero and the pointer is unchanged.
- R9: After all channels are loaded, each enabled channel in ascending order raises a bus error event if its source is zero, below WIN_BASE or above WIN_BASE+WIN_SIZE. Otherwise it raises a start-of-frame event if command bit 22 is set, and then an end-of-frame event if command bit 21 is set.
- R10: Events are single-cycle pulses, at most one per cycle, and `evt_ch_o` gives the channel they belong to.
- R11: `busy_o` rises the cycle after an accepted frame start and falls when the last channel's frame pass ends. A frame start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| main_en_i | input | 1 | Main controller enable |
| dual_scan_i | input | 1 | Dual-scan mode bit |
| ovl1_en_i | input | 1 | Overlay 1 enable |
| ovl2_en_i | input | 1 | Overlay 2 enable |
| cursor_en_i | input | 1 | Hardware cursor enable |
| frame_start_i | input | 1 | Frame start pulse |
| busy_o | output | 1 | Load or frame pass in progress |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | 32 | Word read address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Read data |
| evt_sof_o | output | 1 | Start-of-frame event |
| evt_eof_o | output | 1 | End-of-frame event |
| evt_branch_o | output | 1 | Branch-taken event |
| evt_berr_o | output | 1 | Bus error event |
| evt_ch_o | output | 3 | Channel of the current event |

## Verification
The bench builds the block with the default seven channels and the window base at 0xA0000000, but it shrinks the window to 4 KiB. With that size both ends of the descriptor check (a descriptor ending exactly on the top edge, one starting 8 bytes later, one below the base) and the inclusive top edge of the source check can be reached with small hand-placed descriptors. The memory model's acknowledge latency is varied between zero and two wait cycles, so the request-hold rule is exercised. A second frame start is also issued while a fetch is still stalled.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam logic [31:0] PTR_WR_MASK = 32'hFFFF_FFF0;
  localparam logic [31:0] BR_WR_MASK  = 32'hFFFF_FFF3;
  localparam int CMD_EOF_BIT = 21;
  localparam int CMD_SOF_BIT = 22;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_READ, ST_CHECK, ST_SOF, ST_EOF
  } fdf_state_e;

  // descriptor occupies [a, a+16) and must sit inside [base, base+size]
  function automatic logic desc_in_win(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [31:0] size);
    logic [32:0] a_end, w_end;
    a_end = {1'b0, a} + 33'd16;
    w_end = {1'b0, base} + {1'b0, size};
    return (a >= base) && (a_end <= w_end);
  endfunction

  function automatic logic src_in_win(input logic [31:0] s,
                                      input logic [31:0] base,
                                      input logic [31:0] size);
    logic [32:0] w_end;
    w_end = {1'b0, base} + {1'b0, size};
    return (s != 32'd0) && (s >= base) && ({1'b0, s} <= w_end);
  endfunction
endpackage

// File: rtl/fdf_chan.sv
module fdf_chan
  import fdf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ptr_wr_i,
  input  logic        br_wr_i,
  input  logic [31:0] wdata_i,
  input  logic        src_clr_i,
  input  logic        br_clr_i,
  input  logic        ld_we_i,
  input  logic [1:0]  ld_idx_i,
  input  logic [31:0] ld_data_i,
  output logic [31:0] ptr_o,
  output logic [31:0] src_o,
  output logic [31:0] id_o,
  output logic [31:0] cmd_o,
  output logic [31:0] br_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      src_o <= '0;
      id_o  <= '0;
      cmd_o <= '0;
      br_o  <= '0;
    end else begin
      // fetch engine wins over the register bus
      if (ld_we_i && ld_idx_i == 2'd0) ptr_o <= ld_data_i;
      else if (ptr_wr_i)               ptr_o <= wdata_i & PTR_WR_MASK;

      if (src_clr_i)                         src_o <= '0;
      else if (ld_we_i && ld_idx_i == 2'd1)  src_o <= ld_data_i;

      if (ld_we_i && ld_idx_i == 2'd2) id_o  <= ld_data_i;
      if (ld_we_i && ld_idx_i == 2'd3) cmd_o <= ld_data_i;

      if (br_clr_i)     br_o <= {br_o[31:1], 1'b0};
      else if (br_wr_i) br_o <= wdata_i & BR_WR_MASK;
    end
  end

  a_r7_branch_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_clr_i |=> !br_o[0]);
  a_r5_src_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_clr_i |=> (src_o == 32'd0));
  a_r3_ptr_write_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_wr_i && !ld_we_i) |=> (ptr_o[3:0] == 4'd0));
endmodule

// File: rtl/fdf_seq.sv
module fdf_seq
  import fdf_pkg::*;
#(
  parameter int          NUM_CH   = 7,
  parameter int          CH_W     = 3,
  parameter logic [31:0] WIN_BASE = 32'hA000_0000,
  parameter logic [31:0] WIN_SIZE = 32'h0400_0000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_start_i,
  input  logic [NUM_CH-1:0]        ch_en_i,
  input  logic [NUM_CH-1:0][31:0]  ptr_i,
  input  logic [NUM_CH-1:0][31:0]  src_i,
  input  logic [NUM_CH-1:0]        br_req_i,
  input  logic [NUM_CH-1:0]        br_int_i,
  input  logic [NUM_CH-1:0][27:0]  br_addr_i,
  input  logic [NUM_CH-1:0]        sof_en_i,
  input  logic [NUM_CH-1:0]        eof_en_i,
  output logic                     mem_req_o,
  output logic [31:0]              mem_addr_o,
  input  logic                     mem_ack_i,
  input  logic [31:0]              mem_rdata_i,
  output logic                     src_clr_o,
  output logic [NUM_CH-1:0]        br_clr_o,
  output logic [NUM_CH-1:0]        ld_we_o,
  output logic [1:0]               ld_idx_o,
  output logic [31:0]              ld_data_o,
  output logic                     busy_o,
  output logic                     evt_sof_o,
  output logic                     evt_eof_o,
  output logic                     evt_branch_o,
  output logic                     evt_berr_o,
  output logic [CH_W-1:0]          evt_ch_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  fdf_state_e      st_q, st_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [1:0]      idx_q, idx_d;
  logic [31:0]     base_q, base_d;
  logic [31:0]     desc_addr;
  logic            next_load, next_frame, last_ch;

  assign last_ch   = (ch_q == LAST_CH);
  assign desc_addr = br_req_i[ch_q] ? {br_addr_i[ch_q], 4'h0} : ptr_i[ch_q];

  always_comb begin
    st_d         = st_q;
    ch_d         = ch_q;
    idx_d        = idx_q;
    base_d       = base_q;
    next_load    = 1'b0;
    next_frame   = 1'b0;
    mem_req_o    = 1'b0;
    src_clr_o    = 1'b0;
    br_clr_o     = '0;
    ld_we_o      = '0;
    evt_sof_o    = 1'b0;
    evt_eof_o    = 1'b0;
    evt_branch_o = 1'b0;
    evt_berr_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (frame_start_i) begin
        src_clr_o = 1'b1;
        ch_d      = '0;
        st_d      = ST_LOAD;
      end
      ST_LOAD: begin
        if (ch_en_i[ch_q]) begin
          br_clr_o[ch_q] = br_req_i[ch_q];
          evt_branch_o   = br_req_i[ch_q] & br_int_i[ch_q];
          if (desc_in_win(desc_addr, WIN_BASE, WIN_SIZE)) begin
            base_d = desc_addr;
            idx_d  = 2'd0;
            st_d   = ST_READ;
          end else begin
            next_load = 1'b1;
          end
        end else begin
          next_load = 1'b1;
        end
      end
      ST_READ: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          ld_we_o[ch_q] = 1'b1;
          if (idx_q == 2'd3) next_load = 1'b1;
          else               idx_d = idx_q + 2'd1;
        end
      end
      ST_CHECK: begin
        if (!ch_en_i[ch_q]) begin
          next_frame = 1'b1;
        end else if (!src_in_win(src_i[ch_q], WIN_BASE, WIN_SIZE)) begin
          evt_berr_o = 1'b1;
          next_frame = 1'b1;
        end else begin
          st_d = ST_SOF;
        end
      end
      ST_SOF: begin
        evt_sof_o = sof_en_i[ch_q];
        st_d      = ST_EOF;
      end
      ST_EOF: begin
        evt_eof_o  = eof_en_i[ch_q];
        next_frame = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase

    if (next_load) begin
      if (last_ch) begin ch_d = '0; st_d = ST_CHECK; end
      else begin ch_d = ch_q + CH_W'(1); st_d = ST_LOAD; end
    end
    if (next_frame) begin
      if (last_ch) begin ch_d = '0; st_d = ST_IDLE; end
      else begin ch_d = ch_q + CH_W'(1); st_d = ST_CHECK; end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      idx_q  <= '0;
      base_q <= '0;
    end else begin
      st_q   <= st_d;
      ch_q   <= ch_d;
      idx_q  <= idx_d;
      base_q <= base_d;
    end
  end

  assign mem_addr_o = base_q + {28'd0, idx_q, 2'b00};
  assign ld_idx_o   = idx_q;
  assign ld_data_o  = mem_rdata_i;
  assign busy_o     = (st_q != ST_IDLE);
  assign evt_ch_o   = ch_q;

  a_r6_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r10_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({evt_sof_o, evt_eof_o, evt_branch_o, evt_berr_o}) <= 1);
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_req_o || evt_sof_o || evt_eof_o || evt_branch_o || evt_berr_o));
  a_r8_read_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o >= WIN_BASE &&
                   {1'b0, mem_addr_o} < {1'b0, WIN_BASE} + {1'b0, WIN_SIZE}));
endmodule

// File: rtl/lcd_desc_fetch.sv
module lcd_desc_fetch
  import fdf_pkg::*;
#(
  parameter int          NUM_CH   = 7,
  parameter int          ADDR_W   = 12,
  parameter int          CH_BASE  = 'h200,
  parameter int          BR_BASE  = 'h100,
  parameter logic [31:0] WIN_BASE = 32'hA000_0000,
  parameter logic [31:0] WIN_SIZE = 32'h0400_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              main_en_i,
  input  logic              dual_scan_i,
  input  logic              ovl1_en_i,
  input  logic              ovl2_en_i,
  input  logic              cursor_en_i,
  input  logic              frame_start_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              evt_sof_o,
  output logic              evt_eof_o,
  output logic              evt_branch_o,
  output logic              evt_berr_o,
  output logic [2:0]        evt_ch_o
);
  localparam int CH_W = 3;

  logic [NUM_CH-1:0][31:0] ptr, src, id, cmd, br;
  logic [NUM_CH-1:0][27:0] br_addr;
  logic [NUM_CH-1:0]       ch_en, br_req, br_int, sof_en, eof_en;
  logic [NUM_CH-1:0]       hit_ptr, hit_src, hit_id, hit_cmd, hit_br;
  logic [NUM_CH-1:0]       br_clr, ld_we;
  logic [1:0]              ld_idx;
  logic [31:0]             ld_data;
  logic                    src_clr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign hit_ptr[c] = (reg_addr_i == ADDR_W'(CH_BASE + 16*c));
    assign hit_src[c] = (reg_addr_i == ADDR_W'(CH_BASE + 16*c + 4));
    assign hit_id[c]  = (reg_addr_i == ADDR_W'(CH_BASE + 16*c + 8));
    assign hit_cmd[c] = (reg_addr_i == ADDR_W'(CH_BASE + 16*c + 12));
    assign hit_br[c]  = (reg_addr_i == ADDR_W'(BR_BASE + 4*c));

    if (c == 0) begin : g_en_main
      assign ch_en[c] = main_en_i;
    end else if (c == 1) begin : g_en_ovl1
      assign ch_en[c] = ovl1_en_i | dual_scan_i;
    end else if (c <= 4) begin : g_en_ovl2
      assign ch_en[c] = ovl2_en_i;
    end else if (c == 5) begin : g_en_cursor
      assign ch_en[c] = cursor_en_i;
    end else begin : g_en_none
      assign ch_en[c] = 1'b0;
    end

    assign br_req[c]  = br[c][0];
    assign br_int[c]  = br[c][1];
    assign br_addr[c] = br[c][31:4];
    assign sof_en[c]  = cmd[c][CMD_SOF_BIT];
    assign eof_en[c]  = cmd[c][CMD_EOF_BIT];

    fdf_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ptr_wr_i  (reg_wr_i & hit_ptr[c]),
      .br_wr_i   (reg_wr_i & hit_br[c]),
      .wdata_i   (reg_wdata_i),
      .src_clr_i (src_clr),
      .br_clr_i  (br_clr[c]),
      .ld_we_i   (ld_we[c]),
      .ld_idx_i  (ld_idx),
      .ld_data_i (ld_data),
      .ptr_o     (ptr[c]),
      .src_o     (src[c]),
      .id_o      (id[c]),
      .cmd_o     (cmd[c]),
      .br_o      (br[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit_ptr[c]) reg_rdata_o = reg_rdata_o | ptr[c];
      if (hit_src[c]) reg_rdata_o = reg_rdata_o | src[c];
      if (hit_id[c])  reg_rdata_o = reg_rdata_o | id[c];
      if (hit_cmd[c]) reg_rdata_o = reg_rdata_o | cmd[c];
      if (hit_br[c])  reg_rdata_o = reg_rdata_o | br[c];
    end
  end

  fdf_seq #(
    .NUM_CH   (NUM_CH),
    .CH_W     (CH_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .ch_en_i       (ch_en),
    .ptr_i         (ptr),
    .src_i         (src),
    .br_req_i      (br_req),
    .br_int_i      (br_int),
    .br_addr_i     (br_addr),
    .sof_en_i      (sof_en),
    .eof_en_i      (eof_en),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_ack_i     (mem_ack_i),
    .mem_rdata_i   (mem_rdata_i),
    .src_clr_o     (src_clr),
    .br_clr_o      (br_clr),
    .ld_we_o       (ld_we),
    .ld_idx_o      (ld_idx),
    .ld_data_o     (ld_data),
    .busy_o        (busy_o),
    .evt_sof_o     (evt_sof_o),
    .evt_eof_o     (evt_eof_o),
    .evt_branch_o  (evt_branch_o),
    .evt_berr_o    (evt_berr_o),
    .evt_ch_o      (evt_ch_o)
  );

  a_r9_sof_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_sof_o |-> cmd[evt_ch_o][CMD_SOF_BIT]);
  a_r9_eof_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_eof_o |-> cmd[evt_ch_o][CMD_EOF_BIT]);
  a_r4_no_event_on_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_sof_o || evt_eof_o || evt_berr_o || evt_branch_o) |-> ch_en[evt_ch_o]);
  a_r8_berr_means_bad_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_berr_o |-> !src_in_win(src[evt_ch_o], WIN_BASE, WIN_SIZE));
endmodule

// File: tb/lcd_desc_fetch_bench.sv
`timescale 1ns/1ps
module lcd_desc_fetch_bench;
  localparam logic [31:0] WB = 32'hA000_0000;
  localparam logic [31:0] WS = 32'h0000_1000;
  localparam int K_BR = 1, K_SOF = 2, K_EOF = 3, K_BERR = 4;
  localparam logic [31:0] C_SOF = 32'h0040_0000;
  localparam logic [31:0] C_EOF = 32'h0020_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        main_en = 1'b0, dual_scan = 1'b0, ovl1_en = 1'b0, ovl2_en = 1'b0, cursor_en = 1'b0;
  logic        frame_start = 1'b0;
  logic        busy, mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        evt_sof, evt_eof, evt_branch, evt_berr;
  logic [2:0]  evt_ch;

  int n_chk = 0, n_bad = 0, multi_evt = 0, lat = 0, wcnt = 0;
  int ev_q[$], exp_ev[$];
  logic [31:0] rd_q[$], exp_rd[$];
  logic [31:0] mem [logic [31:0]];

  always #5 clk = ~clk;

  lcd_desc_fetch #(.WIN_BASE(WB), .WIN_SIZE(WS)) u_lcd_desc_fetch (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .main_en_i(main_en),
    .dual_scan_i(dual_scan), .ovl1_en_i(ovl1_en), .ovl2_en_i(ovl2_en),
    .cursor_en_i(cursor_en), .frame_start_i(frame_start), .busy_o(busy),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .evt_sof_o(evt_sof), .evt_eof_o(evt_eof),
    .evt_branch_o(evt_branch), .evt_berr_o(evt_berr), .evt_ch_o(evt_ch));

  // memory model with programmable wait cycles
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (wcnt >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
        rd_q.push_back(mem_addr);
        wcnt = 0;
      end else begin
        mem_ack = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ack = 1'b0;
      wcnt = 0;
    end
  end

  // event monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if ((32'(evt_sof) + 32'(evt_eof) + 32'(evt_branch) + 32'(evt_berr)) > 1) multi_evt++;
      if (evt_branch) ev_q.push_back(K_BR * 16 + int'(evt_ch));
      if (evt_sof)    ev_q.push_back(K_SOF * 16 + int'(evt_ch));
      if (evt_eof)    ev_q.push_back(K_EOF * 16 + int'(evt_ch));
      if (evt_berr)   ev_q.push_back(K_BERR * 16 + int'(evt_ch));
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    mem[a] = w0; mem[a + 4] = w1; mem[a + 8] = w2; mem[a + 12] = w3;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(req, 32'(busy), 32'd0);
  endtask

  task automatic run_frame(input string req);
    ev_q.delete(); rd_q.delete();
    pulse_start();
    wait_idle(req);
  endtask

  task automatic exp_reads(input logic [31:0] a);
    for (int i = 0; i < 4; i++) exp_rd.push_back(a + 32'(4 * i));
  endtask

  task automatic chk_reads(input string req);
    chk({req, " read count"}, 32'(rd_q.size()), 32'(exp_rd.size()));
    for (int i = 0; i < exp_rd.size() && i < rd_q.size(); i++)
      chk({req, " read addr"}, rd_q[i], exp_rd[i]);
    exp_rd.delete();
  endtask

  task automatic chk_events(input string req);
    chk({req, " event count"}, 32'(ev_q.size()), 32'(exp_ev.size()));
    for (int i = 0; i < exp_ev.size() && i < ev_q.size(); i++)
      chk({req, " event"}, 32'(ev_q[i]), 32'(exp_ev[i]));
    exp_ev.delete();
  endtask

  task automatic set_en(input logic m, input logic d, input logic o1, input logic o2, input logic cu);
    @(negedge clk);
    main_en = m; dual_scan = d; ovl1_en = o1; ovl2_en = o2; cursor_en = cu;
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 events", 32'({evt_sof, evt_eof, evt_branch, evt_berr}), 32'd0);
    rd_chk("R1 ptr0", 12'h200, 32'd0);
    rd_chk("R1 cmd6", 12'h26C, 32'd0);
    rd_chk("R1 br3", 12'h10C, 32'd0);
  endtask

  task automatic t_regmap();
    wr(12'h200, 32'hA000_012F);
    rd_chk("R3 ptr write mask", 12'h200, 32'hA000_0120);
    wr(12'h204, 32'h1234_5678);
    rd_chk("R3 src write ignored", 12'h204, 32'd0);
    wr(12'h20C, 32'hFFFF_FFFF);
    rd_chk("R3 cmd write ignored", 12'h20C, 32'd0);
    wr(12'h114, 32'hFFFF_FFFF);
    rd_chk("R3 branch write mask", 12'h114, 32'hFFFF_FFF3);
    wr(12'h114, 32'd0);
    rd_chk("R2 undefined offset", 12'h202, 32'd0);
    wr(12'h230, 32'hA000_0330);
    rd_chk("R2 ch3 ptr", 12'h230, 32'hA000_0330);
    rd_chk("R2 ch2 ptr untouched", 12'h220, 32'd0);
    wr(12'h270, 32'hA000_0770);
    rd_chk("R2 ch7 read zero", 12'h270, 32'd0);
    rd_chk("R2 ch7 write no alias", 12'h200, 32'hA000_0120);
    wr(12'h11C, 32'hA000_0001);
    rd_chk("R2 branch ch7 zero", 12'h11C, 32'd0);
  endtask

  task automatic t_basic();
    lat = 0;
    wr(12'h200, 32'hA000_0100);
    put_desc(32'hA000_0100, 32'hA000_0200, 32'hA000_0800, 32'h11, C_SOF | C_EOF | 32'h40);
    set_en(1, 0, 0, 0, 0);
    run_frame("R11 basic");
    exp_reads(32'hA000_0100);
    chk_reads("R6 basic");
    exp_ev.push_back(K_SOF * 16); exp_ev.push_back(K_EOF * 16);
    chk_events("R9 basic");
    rd_chk("R6 ptr from word0", 12'h200, 32'hA000_0200);
    rd_chk("R6 src from word1", 12'h204, 32'hA000_0800);
    rd_chk("R6 id from word2", 12'h208, 32'h11);
    rd_chk("R6 cmd from word3", 12'h20C, C_SOF | C_EOF | 32'h40);
  endtask

  task automatic t_multi();
    lat = 1;
    put_desc(32'hA000_0200, 32'hA000_0100, 32'hA000_0900, 32'h22, C_SOF);
    put_desc(32'hA000_0300, 32'hA000_0300, 32'h0, 32'h33, C_SOF | C_EOF);
    put_desc(32'hA000_0340, 32'hA000_0340, WB + WS, 32'h34, C_EOF);
    put_desc(32'hA000_0380, 32'hA000_0380, WB + WS + 4, 32'h38, C_SOF | C_EOF);
    wr(12'h220, 32'hA000_0300);
    wr(12'h230, 32'hA000_0340);
    wr(12'h240, 32'hA000_0380);
    set_en(1, 0, 0, 1, 0);
    run_frame("R11 multi");
    exp_reads(32'hA000_0200); exp_reads(32'hA000_0300);
    exp_reads(32'hA000_0340); exp_reads(32'hA000_0380);
    chk_reads("R6 ascending multi");
    exp_ev.push_back(K_SOF * 16 + 0);
    exp_ev.push_back(K_BERR * 16 + 2);
    exp_ev.push_back(K_EOF * 16 + 3);
    exp_ev.push_back(K_BERR * 16 + 4);
    chk_events("R9 multi");
    rd_chk("R6 chain ptr", 12'h200, 32'hA000_0100);
    rd_chk("R4 ch4 id", 12'h248, 32'h38);
    chk("R10 single event per cycle", 32'(multi_evt), 32'd0);
  endtask

  task automatic t_branch();
    lat = 0;
    put_desc(32'hA000_0400, 32'hA000_0600, 32'hA000_0A00, 32'h44, C_SOF | C_EOF);
    put_desc(32'hA000_0500, 32'hA000_0100, 32'hA000_0B00, 32'h55, 32'h0);
    set_en(1, 0, 0, 0, 0);
    wr(12'h100, 32'hA000_0403);
    run_frame("R11 branch");
    exp_reads(32'hA000_0400);
    chk_reads("R7 branch fetch");
    exp_ev.push_back(K_BR * 16); exp_ev.push_back(K_SOF * 16); exp_ev.push_back(K_EOF * 16);
    chk_events("R7 branch event");
    rd_chk("R7 branch bit0 cleared", 12'h100, 32'hA000_0402);
    rd_chk("R7 ptr after branch", 12'h200, 32'hA000_0600);
    rd_chk("R5 disabled src cleared", 12'h234, 32'd0);
    rd_chk("R5 disabled id kept", 12'h238, 32'h34);
    wr(12'h100, 32'hA000_0501);
    run_frame("R11 branch2");
    exp_reads(32'hA000_0500);
    chk_reads("R7 quiet branch fetch");
    chk_events("R7 no branch event");
    rd_chk("R7 quiet branch cleared", 12'h100, 32'hA000_0500);
    rd_chk("R7 ptr after quiet branch", 12'h200, 32'hA000_0100);
  endtask

  task automatic t_window();
    put_desc(WB + WS - 16, WB + WS - 8, 32'hA000_0C00, 32'h66, C_SOF | C_EOF);
    wr(12'h200, WB + WS - 16);
    run_frame("R11 window");
    exp_reads(WB + WS - 16);
    chk_reads("R8 top edge fetched");
    exp_ev.push_back(K_SOF * 16); exp_ev.push_back(K_EOF * 16);
    chk_events("R8 top edge events");
    run_frame("R11 window2");
    chk_reads("R8 past top no read");
    exp_ev.push_back(K_BERR * 16);
    chk_events("R8 past top berr");
    rd_chk("R8 ptr kept", 12'h200, WB + WS - 8);
    rd_chk("R8 src zero", 12'h204, 32'd0);
    rd_chk("R8 id kept", 12'h208, 32'h66);
    wr(12'h200, 32'h9FFF_FFF0);
    run_frame("R11 window3");
    chk_reads("R8 below base no read");
    exp_ev.push_back(K_BERR * 16);
    chk_events("R8 below base berr");
  endtask

  task automatic t_enables();
    put_desc(32'hA000_0700, 32'hA000_0700, 32'hA000_0D00, 32'h77, C_EOF);
    put_desc(32'hA000_0740, 32'hA000_0740, 32'hA000_0E00, 32'h88, C_SOF);
    put_desc(32'hA000_0780, 32'hA000_0780, 32'hA000_0F00, 32'h99, C_SOF);
    wr(12'h210, 32'hA000_0700);
    wr(12'h250, 32'hA000_0740);
    wr(12'h260, 32'hA000_0780);
    set_en(0, 1, 0, 0, 0);
    run_frame("R11 dual");
    exp_reads(32'hA000_0700);
    chk_reads("R4 dual-scan enables ch1");
    exp_ev.push_back(K_EOF * 16 + 1);
    chk_events("R4 ch1 events");
    rd_chk("R5 cursor off ptr kept", 12'h250, 32'hA000_0740);
    rd_chk("R5 cursor off id kept", 12'h258, 32'h0);
    set_en(0, 0, 0, 0, 1);
    run_frame("R11 cursor");
    exp_reads(32'hA000_0740);
    chk_reads("R4 cursor ch5 only, ch6 never");
    exp_ev.push_back(K_SOF * 16 + 5);
    chk_events("R10 cursor tag");
    rd_chk("R4 ch6 id untouched", 12'h268, 32'h0);
    set_en(0, 0, 1, 0, 0);
    wr(12'h210, 32'hA000_0700);
    run_frame("R11 ovl1");
    exp_reads(32'hA000_0700);
    chk_reads("R4 overlay1 enables ch1");
    exp_ev.push_back(K_EOF * 16 + 1);
    chk_events("R4 ovl1 events");
  endtask

  task automatic t_busy();
    lat = 2;
    set_en(1, 0, 0, 0, 0);
    wr(12'h200, 32'hA000_0100);
    ev_q.delete(); rd_q.delete();
    pulse_start();
    chk("R11 busy after start", 32'(busy), 32'd1);
    @(negedge clk); @(negedge clk);
    pulse_start();
    wait_idle("R11 busy drop");
    exp_reads(32'hA000_0100);
    chk_reads("R11 second start ignored");
    exp_ev.push_back(K_SOF * 16); exp_ev.push_back(K_EOF * 16);
    chk_events("R11 one frame only");
    rd_chk("R11 ptr advanced once", 12'h200, 32'hA000_0200);
    chk("R10 single event overall", 32'(multi_evt), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_regmap();
    t_basic();
    t_multi();
    t_branch();
    t_window();
    t_enables();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule